// File: doc/BRIEF.md
# Generic Command Packet Queue Interface

This block sits between a register port and a packet transmitter/receiver pair, and moves generic command packets in both directions. Software queues the payload words of a packet in a write payload queue and then writes a 24-bit header word. The header triggers the packet. Once the header reaches the head of its queue and enough payload is present, the block streams the packet to the transmitter over a valid/ready interface: first the header beat, then the payload words of a long packet.

Response bytes coming back from a receiver are packed least significant byte first into 32-bit words and placed in a read payload queue that software drains. A status register shows the empty and full state of all three queues, a read-in-progress flag and a sticky overflow flag. Software can poll it to see when a transfer has finished, and to see when a response is ready.

A small configuration register drives two enables toward the transmitter. One requests an acknowledge from the peripheral. The other enables tearing-effect reporting.

Top module: `cmdpkt_if`

## Requirements
- R1: The status register (address 3) has fixed bits. Bit 0 is header queue empty and bit 1 is header queue full. Bit 2 is write payload queue empty and bit 3 is write payload queue full. Bit 4 is read payload queue empty and bit 5 is read payload queue full. Bit 6 is read busy and bit 7 is sticky overflow. Upper bits read as zero. After reset the register reads 0x15.
- R2: The configuration register (address 0) holds tearing-effect enable in bit 0 and acknowledge-request enable in bit 1. Both read back, both drive the `te_en` and `ack_req` outputs, and both reset to 0.
- R3: A write to address 1 queues a header. Bits 7:0 are the data type and bits 23:8 are a 16-bit word count or two parameter bytes. The header is sent as one beat with `tx_first`=1 and `tx_data` = {8'h00, header[23:0]}.
- R4: A packet is long when data type bits 3:0 equal 4'h9 and short otherwise. A short packet is a single beat with `tx_last`=1.
- R5: A long packet with word count N is followed by ceil(N/4) payload beats taken in queue order. `tx_last` marks the final beat. With N=0 the header beat itself carries `tx_last`.
- R6: On the final payload beat, bytes at or above byte N mod 4 are sent as zero, unless N mod 4 is 0. Payload bytes are little-endian: the first byte is in bits 7:0.
- R7: A long header is not presented to the transmitter until the write payload queue holds at least min(ceil(N/4), 16) words.
- R8: Receiver bytes are packed least significant byte first, four per word. A byte with `rx_last` set closes the word, and its unused upper bytes are zero.
- R9: Read busy is set when the transmitter accepts a header whose data type bits 3:0 are 4'h4 or 4'h6, or any header while acknowledge-request is enabled. It clears on the byte carrying `rx_last`.
- R10: A push into a full queue is dropped and sets the sticky overflow flag. Writing 1 to status bit 7 clears the flag.
- R11: Reading address 2 returns the oldest read payload word and removes it. When the queue is empty the read returns 0 and changes nothing.
- R12: Each queue holds 16 entries, and its full flag is set after 16 pushes with no pops.
- R13: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the read queue at address 2) |
| reg_addr | input | 2 | Register select: 0 config, 1 header, 2 payload, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| tx_valid | output | 1 | Transmit beat valid |
| tx_ready | input | 1 | Transmitter accepts the beat |
| tx_data | output | 32 | Header or payload word |
| tx_first | output | 1 | Beat is a header |
| tx_last | output | 1 | Final beat of the packet |
| rx_valid | input | 1 | Receiver byte valid |
| rx_byte | input | 8 | Received byte |
| rx_last | input | 1 | Final byte of the response |
| te_en | output | 1 | Tearing-effect enable toward the transmitter |
| ack_req | output | 1 | Acknowledge-request enable toward the transmitter |

## Verification
The assertions assume the transmitter may stall at any time, but that register strobes are never asserted together with a reset. They also assume receiver bytes arrive no faster than one per cycle. The bench keeps to this by driving one register access or receiver byte at a time between clock edges, and it randomises `tx_ready` every cycle. Random packets are sized so that their payload never exceeds the queue. Overflow is reached only in directed cases where the expected drop is modelled.

// File: rtl/cmdpkt_pkg.sv
// Shared types and helpers for the command packet queue interface.
// Assumes 32-bit payload words and 24-bit headers (type byte + 16-bit count).
package cmdpkt_pkg;

    localparam int WORD_W = 32;
    localparam int HDR_W  = 24;

    typedef enum logic [1:0] {
        REG_CFG  = 2'd0,
        REG_HDR  = 2'd1,
        REG_PLD  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_HDR  = 2'd1,
        TX_PLD  = 2'd2
    } tx_state_e;

    // status bit positions (fixed)
    localparam int ST_HDR_EMPTY = 0;
    localparam int ST_HDR_FULL  = 1;
    localparam int ST_WP_EMPTY  = 2;
    localparam int ST_WP_FULL   = 3;
    localparam int ST_RP_EMPTY  = 4;
    localparam int ST_RP_FULL   = 5;
    localparam int ST_RD_BUSY   = 6;
    localparam int ST_OVF       = 7;

    function automatic logic dt_is_long(input logic [7:0] dt);
        return dt[3:0] == 4'h9;
    endfunction

    function automatic logic dt_is_read(input logic [7:0] dt);
        return (dt[3:0] == 4'h4) || (dt[3:0] == 4'h6);
    endfunction

    // keep only the first 'tail' bytes of a word (tail 0 keeps all four)
    function automatic logic [WORD_W-1:0] tail_mask(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] tail);
        logic [WORD_W-1:0] m;
        m = '1;
        for (int b = 1; b < 4; b++) begin
            if (tail != 2'd0 && b >= int'(tail)) m[b*8 +: 8] = 8'h00;
        end
        return w & m;
    endfunction

endpackage

// File: rtl/cmdpkt_fifo.sv
// Synchronous show-ahead queue. A push while full is dropped and flagged
// with a one-cycle 'drop' pulse; a pop while empty is ignored. The head
// reads as zero when empty. Assumes DEPTH >= 2.
module cmdpkt_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic          drop,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          do_push, do_pop;

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

    assign empty   = (count == '0);
    assign full    = (count == DEPTH_C);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign drop    = push && full;
    assign head    = empty ? '0 : mem[rd_ptr];

    // storage write
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R12
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= DEPTH_C);

    // R10
    drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/cmdpkt_tx_seq.sv
// Transmit sequencer: waits for a header and (for long packets) enough
// queued payload, then streams header and payload beats over valid/ready.
// Assumes header bits 7:0 are the type and bits 23:8 the byte count.
module cmdpkt_tx_seq
    import cmdpkt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_empty,
    input  logic [HDR_W-1:0]  hdr_word,
    input  logic              pld_empty,
    input  logic [CW-1:0]     pld_count,
    input  logic [WORD_W-1:0] pld_word,
    input  logic              tx_ready,
    output logic              hdr_pop,
    output logic              pld_pop,
    output logic              hdr_accept,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_first,
    output logic              tx_last
);

    localparam logic [15:0] DEPTH16 = 16'(DEPTH);

    tx_state_e   state;
    logic [15:0] rem_words;
    logic [1:0]  tail_bytes;
    logic [7:0]  dt;
    logic [15:0] wc;
    logic [16:0] words17;
    logic [15:0] words, need;
    logic        is_long, can_start;

    assign dt      = hdr_word[7:0];
    assign wc      = hdr_word[23:8];
    assign words17 = ({1'b0, wc} + 17'd3) >> 2;
    assign words   = words17[15:0];
    assign need    = (words > DEPTH16) ? DEPTH16 : words;
    assign is_long = dt_is_long(dt);
    assign can_start = !hdr_empty && (!is_long || (16'(pld_count) >= need));

    // beat presentation for the current state
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        tx_first = 1'b0;
        tx_last  = 1'b0;
        case (state)
            TX_HDR: begin
                tx_valid = 1'b1;
                tx_data  = {8'h00, hdr_word};
                tx_first = 1'b1;
                tx_last  = !is_long || (words == 16'd0);
            end
            TX_PLD: begin
                tx_valid = !pld_empty;
                tx_last  = (rem_words == 16'd1);
                tx_data  = tx_last ? tail_mask(pld_word, tail_bytes) : pld_word;
            end
            default: ;
        endcase
    end

    assign hdr_accept = (state == TX_HDR) && tx_ready;
    assign hdr_pop    = hdr_accept;
    assign pld_pop    = (state == TX_PLD) && tx_valid && tx_ready;

    // packet sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= TX_IDLE;
            rem_words  <= '0;
            tail_bytes <= '0;
        end else begin
            case (state)
                TX_IDLE: if (can_start) state <= TX_HDR;
                TX_HDR: if (tx_ready) begin
                    rem_words  <= words;
                    tail_bytes <= wc[1:0];
                    state      <= tx_last ? TX_IDLE : TX_PLD;
                end
                TX_PLD: if (pld_pop) begin
                    rem_words <= rem_words - 16'd1;
                    if (tx_last) state <= TX_IDLE;
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    // R13
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

    // R5
    pld_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pld_pop) |-> (state == TX_PLD && rem_words != 16'd0));

endmodule

// File: rtl/cmdpkt_rx_pack.sv
// Packs a receiver byte stream, least significant byte first, into
// 32-bit words. A byte flagged last closes the word zero-padded.
// Assumes at most one byte per cycle.
module cmdpkt_rx_pack
    import cmdpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_last,
    output logic              word_push,
    output logic [WORD_W-1:0] word_data
);

    logic [23:0] acc;
    logic [1:0]  idx;

    assign word_data = {8'h00, acc} | (WORD_W'(rx_byte) << {idx, 3'b000});
    assign word_push = rx_valid && ((idx == 2'd3) || rx_last);

    // byte accumulation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            idx <= '0;
        end else if (rx_valid) begin
            if (word_push) begin
                acc <= '0;
                idx <= '0;
            end else begin
                acc <= word_data[23:0];
                idx <= idx + 2'd1;
            end
        end
    end

    // R8
    pack_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_push |=> (idx == 2'd0 && acc == 24'd0));

endmodule

// File: rtl/cmdpkt_if.sv
// Top of the command packet queue interface: register decode, three
// queues, transmit sequencer, receive packer, read-busy and overflow flags.
// Assumes register strobes are single-cycle and the address is stable with them.
module cmdpkt_if
    import cmdpkt_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [31:0] tx_data,
    output logic        tx_first,
    output logic        tx_last,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    input  logic        rx_last,
    output logic        te_en,
    output logic        ack_req
);

    logic [1:0]        cfg_q;
    logic              ovf_q, busy_q;
    logic              hdr_push, wp_push, rp_pop, ovf_clr;
    logic              hf_empty, hf_full, hf_drop, hf_pop;
    logic              wf_empty, wf_full, wf_drop, wf_pop;
    logic              rf_empty, rf_full, rf_drop;
    logic [CW-1:0]     hf_count, wf_count, rf_count;
    logic [HDR_W-1:0]  hf_head;
    logic [WORD_W-1:0] wf_head, rf_head, rx_word;
    logic              rx_push, hdr_accept, busy_set, busy_clr;
    logic [7:0]        status;
    logic              unused_cnt;

    assign unused_cnt = ^{hf_count, rf_count};

    assign hdr_push = reg_wr && (reg_addr == REG_HDR);
    assign wp_push  = reg_wr && (reg_addr == REG_PLD);
    assign rp_pop   = reg_rd && (reg_addr == REG_PLD);
    assign ovf_clr  = reg_wr && (reg_addr == REG_STAT) && reg_wdata[ST_OVF];

    cmdpkt_fifo #(.W(HDR_W), .DEPTH(DEPTH)) u_hdr_q (
        .clk(clk), .rst_n(rst_n), .push(hdr_push), .push_data(reg_wdata[HDR_W-1:0]),
        .pop(hf_pop), .head(hf_head), .empty(hf_empty), .full(hf_full),
        .drop(hf_drop), .count(hf_count));

    cmdpkt_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_wpld_q (
        .clk(clk), .rst_n(rst_n), .push(wp_push), .push_data(reg_wdata),
        .pop(wf_pop), .head(wf_head), .empty(wf_empty), .full(wf_full),
        .drop(wf_drop), .count(wf_count));

    cmdpkt_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rpld_q (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .push_data(rx_word),
        .pop(rp_pop), .head(rf_head), .empty(rf_empty), .full(rf_full),
        .drop(rf_drop), .count(rf_count));

    cmdpkt_tx_seq #(.DEPTH(DEPTH)) u_tx (
        .clk(clk), .rst_n(rst_n), .hdr_empty(hf_empty), .hdr_word(hf_head),
        .pld_empty(wf_empty), .pld_count(wf_count), .pld_word(wf_head),
        .tx_ready(tx_ready), .hdr_pop(hf_pop), .pld_pop(wf_pop),
        .hdr_accept(hdr_accept), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_first(tx_first), .tx_last(tx_last));

    cmdpkt_rx_pack u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_last(rx_last), .word_push(rx_push), .word_data(rx_word));

    assign busy_set = hdr_accept && (dt_is_read(hf_head[7:0]) || cfg_q[1]);
    assign busy_clr = rx_valid && rx_last;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)                                  cfg_q <= '0;
        else if (reg_wr && (reg_addr == REG_CFG))    cfg_q <= reg_wdata[1:0];
    end

    // sticky overflow flag: any dropped push sets it, write-one clears it
    always_ff @(posedge clk) begin
        if (!rst_n)                              ovf_q <= 1'b0;
        else if (hf_drop || wf_drop || rf_drop)  ovf_q <= 1'b1;
        else if (ovf_clr)                        ovf_q <= 1'b0;
    end

    // read-busy flag: set by a response-expecting header, cleared by the final byte
    always_ff @(posedge clk) begin
        if (!rst_n)        busy_q <= 1'b0;
        else if (busy_set) busy_q <= 1'b1;
        else if (busy_clr) busy_q <= 1'b0;
    end

    assign status = {ovf_q, busy_q, rf_full, rf_empty, wf_full, wf_empty, hf_full, hf_empty};
    assign te_en   = cfg_q[0];
    assign ack_req = cfg_q[1];

    // register read mux
    always_comb begin
        case (reg_sel_e'(reg_addr))
            REG_CFG:  reg_rdata = {30'd0, cfg_q};
            REG_PLD:  reg_rdata = rf_head;
            REG_STAT: reg_rdata = {24'd0, status};
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_last && !busy_set) |=> !busy_q);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wf_drop || hf_drop || rf_drop) |=> ovf_q);

    // R1
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(status[ST_HDR_EMPTY] && status[ST_HDR_FULL]) && !(status[ST_WP_EMPTY] && status[ST_WP_FULL])
        && !(status[ST_RP_EMPTY] && status[ST_RP_FULL]));

endmodule

// File: tb/sim_cmdpkt_if.sv
module sim_cmdpkt_if;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        tx_valid, tx_ready = 1'b0, tx_first, tx_last;
    logic [31:0] tx_data;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        te_en, ack_req;

    int checks = 0, errors = 0;
    int rmode = 0;
    logic [31:0] exp_data [0:1023];
    bit          exp_first [0:1023];
    bit          exp_last [0:1023];
    int exp_n = 0, cap_n = 0;
    bit          prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    bit          rnow;

    cmdpkt_if u0 (.*);

    always #10 clk = ~clk;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] bmask(logic [31:0] w, int wc);
        case (wc % 4)
            1: return w & 32'h0000_00FF;
            2: return w & 32'h0000_FFFF;
            3: return w & 32'h00FF_FFFF;
            default: return w;
        endcase
    endfunction

    task automatic exp_push(logic [31:0] d, bit f, bit l);
        exp_data[exp_n] = d; exp_first[exp_n] = f; exp_last[exp_n] = l;
        exp_n++;
    endtask

    // transmitter model: drives tx_ready, checks hold and beat order
    always @(negedge clk) begin
        if (!rst_n) rnow = 1'b0;
        else if (rmode == 0) rnow = 1'b0;
        else if (rmode == 1) rnow = 1'b1;
        else rnow = 1'($urandom_range(0, 1));
        if (prev_stall) begin
            chk("R13 hold valid", {31'd0, tx_valid}, 32'd1);
            chk("R13 hold data", tx_data, prev_data);
        end
        prev_stall = tx_valid && !rnow;
        prev_data  = tx_data;
        tx_ready   = rnow;
        if (tx_valid && rnow) begin
            if (cap_n >= exp_n) chk("R5 unexpected beat", tx_data, 32'hDEAD_BEEF);
            else begin
                chk("R3/R5 beat data", tx_data, exp_data[cap_n]);
                chk("R3/R4 beat first/last", {30'd0, tx_first, tx_last},
                    {30'd0, exp_first[cap_n], exp_last[cap_n]});
            end
            cap_n++;
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rx_send(logic [7:0] b, bit l);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b; rx_last = l;
        @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            reg_read(2'd3, s);
            if (s[0] && s[2]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // long packet with random payload; the final word carries junk in its pad bytes
    task automatic send_long(logic [7:0] dt, int wc);
        int nw = (wc + 3) / 4;
        logic [31:0] w;
        exp_push({8'h00, 16'(wc), dt}, 1'b1, nw == 0);
        for (int i = 0; i < nw; i++) begin
            w = $urandom;
            reg_write(2'd2, w);
            exp_push((i == nw - 1) ? bmask(w, wc) : w, 1'b0, i == nw - 1);
        end
        reg_write(2'd1, {8'h00, 16'(wc), dt});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5EED_0007));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 config reset
        reg_read(2'd3, v); chk("R1 reset status", v, 32'h15);
        reg_read(2'd0, v); chk("R2 reset cfg", v, 32'h0);
        chk("R13 no beat after reset", {31'd0, tx_valid}, 32'd0);

        // R2 config bits
        reg_write(2'd0, 32'h3);
        reg_read(2'd0, v); chk("R2 cfg readback", v, 32'h3);
        chk("R2 te_en/ack_req", {30'd0, ack_req, te_en}, 32'h3);
        reg_write(2'd0, 32'h1);
        chk("R2 ack off te on", {30'd0, ack_req, te_en}, 32'h1);
        reg_write(2'd0, 32'h0);

        // R7 header before payload must wait
        rmode = 0;
        exp_push({8'h00, 16'd8, 8'h29}, 1'b1, 1'b0);
        exp_push(32'hA1A2A3A4, 1'b0, 1'b0);
        exp_push(32'hB1B2B3B4, 1'b0, 1'b1);
        reg_write(2'd1, {8'h00, 16'd8, 8'h29});
        repeat (3) @(negedge clk);
        chk("R7 waits with no payload", {31'd0, tx_valid}, 32'd0);
        reg_write(2'd2, 32'hA1A2A3A4);
        repeat (3) @(negedge clk);
        chk("R7 waits with one word", {31'd0, tx_valid}, 32'd0);
        reg_write(2'd2, 32'hB1B2B3B4);
        repeat (3) @(negedge clk);
        chk("R7 starts when payload present", {30'd0, tx_valid, tx_first}, 32'h3);
        rmode = 1;
        wait_idle();

        // R12/R10 write payload queue full and overflow
        rmode = 0;
        for (int i = 0; i < 17; i++) reg_write(2'd2, 32'h100 + 32'(i));
        reg_read(2'd3, v); chk("R12/R10 payload full + overflow", v, 32'h99);
        reg_write(2'd3, 32'h80);
        reg_read(2'd3, v); chk("R10 overflow cleared", v, 32'h19);
        exp_push({8'h00, 16'd64, 8'h39}, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) exp_push(32'h100 + 32'(i), 1'b0, i == 15);
        reg_write(2'd1, {8'h00, 16'd64, 8'h39});
        rmode = 2;
        wait_idle();
        reg_read(2'd3, v); chk("R10 dropped word not sent", v, 32'h15);

        // R12/R4 header queue full with short packets
        rmode = 0;
        for (int i = 0; i < 17; i++) begin
            if (i < 16) exp_push({8'h00, 16'(i * 3), 8'h05}, 1'b1, 1'b1);
            reg_write(2'd1, {8'h00, 16'(i * 3), 8'h05});
        end
        reg_read(2'd3, v); chk("R12/R10 header full + overflow", v, 32'h96);
        reg_write(2'd3, 32'h80);
        rmode = 1;
        wait_idle();
        reg_read(2'd3, v); chk("R4 short headers drained", v, 32'h15);

        // R6 zero-count and partial final word
        rmode = 2;
        send_long(8'h29, 0); wait_idle();
        send_long(8'h39, 5); wait_idle();
        send_long(8'h29, 7); wait_idle();

        // R9/R8/R11 read request and response
        rmode = 1;
        exp_push({8'h00, 16'h0012, 8'h14}, 1'b1, 1'b1);
        reg_write(2'd1, {8'h00, 16'h0012, 8'h14});
        wait_idle();
        reg_read(2'd3, v); chk("R9 busy after read request", v, 32'h55);
        rx_send(8'h11, 0); rx_send(8'h22, 0); rx_send(8'h33, 0);
        rx_send(8'h44, 0); rx_send(8'h55, 1);
        reg_read(2'd3, v); chk("R9 busy cleared, data queued", v, 32'h05);
        reg_read(2'd2, v); chk("R8 first word little-endian", v, 32'h44332211);
        reg_read(2'd2, v); chk("R8 partial word zero-padded", v, 32'h00000055);
        reg_read(2'd2, v); chk("R11 empty read returns zero", v, 32'h0);
        reg_read(2'd3, v); chk("R11 empty read no effect", v, 32'h15);

        // R9 acknowledge request makes any header busy
        reg_write(2'd0, 32'h2);
        exp_push({8'h00, 16'h0077, 8'h05}, 1'b1, 1'b1);
        reg_write(2'd1, {8'h00, 16'h0077, 8'h05});
        wait_idle();
        reg_read(2'd3, v); chk("R9 busy with ack enable", v, 32'h55);
        rx_send(8'h7E, 1);
        reg_read(2'd3, v); chk("R9 ack response clears busy", v, 32'h05);
        reg_read(2'd2, v); chk("R8 single byte word", v, 32'h0000007E);
        reg_write(2'd0, 32'h0);

        // R12/R10 read payload queue full
        for (int i = 0; i < 17; i++) rx_send(8'(i + 1), 1);
        reg_read(2'd3, v); chk("R12/R10 read queue full + overflow", v, 32'hA5);
        for (int i = 0; i < 16; i++) begin
            reg_read(2'd2, v); chk("R8/R11 drained word", v, 32'(i + 1));
        end
        reg_write(2'd3, 32'h80);
        reg_read(2'd3, v); chk("R1 back to idle", v, 32'h15);

        // random packets
        rmode = 2;
        for (int p = 0; p < 40; p++) begin
            int k = $urandom_range(0, 3);
            if (k < 2) send_long((k == 0) ? 8'h29 : 8'h39, $urandom_range(0, 40));
            else begin
                logic [15:0] prm = 16'($urandom);
                exp_push({8'h00, prm, (k == 2) ? 8'h03 : 8'h15}, 1'b1, 1'b1);
                reg_write(2'd1, {8'h00, prm, (k == 2) ? 8'h03 : 8'h15});
            end
            wait_idle();
        end
        chk("R5 all expected beats seen", 32'(cap_n), 32'(exp_n));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule